// File: doc/BRIEF.md
# Single-Wire Bus Address Selection Layer

This block sits between the bit-slot interface of a single-wire slave and its function layer. After every bus reset it takes the first eight bits the master writes as a command byte. The command either reads out the slave's 64-bit identifier, matches it against one the master sends, selects the slave without addressing, or runs a bitwise search. The search lets a master enumerate every slave sharing one open-drain wire.

The identifier has three fields. The family code is a parameter. The serial number comes in on a port. The check byte is computed in logic from those two. When selection succeeds, `selected` goes high and stays high until the next bus reset. While selected, write slots are passed on to the function layer, and read slots are answered with the function layer's bit. A slave that loses a match or a search, or that sees an unknown command, releases the wire (drives 1) and ignores all slots until the next bus reset.

The block does not handle slot timing. The bit layer gives one-cycle strobes for each write slot (`wr_slot` with `wr_bit`) and each read slot (`rd_slot`). It also samples `tx_bit`, which is the value the slave presents in the coming read slot, where 1 means released.

Top module: `ow_netaddr_layer`

## Requirements
- R1: After `rst_n` is deasserted, `selected`, `fwd_valid` and `fn_rd` are 0 and `tx_bit` is 1.
- R2: The identifier is laid out as follows: bits [7:0] hold the family code (default 09h), bits [55:8] hold `serial_num`, and bits [63:56] hold the check byte. The check byte is a CRC with polynomial x^8+x^5+x^4+1. Its register starts at zero and takes bits 0..55 of the identifier, bit 0 first. After command 33h, the next 64 read slots return identifier bits 0 to 63 in order, and `selected` rises after the last of them.
- R3: Command CCh raises `selected` in the cycle after its 8th bit, with no address slots. `selected` is still 0 after 7 bits.
- R4: After command 55h the slave compares the next 64 write slots, in order, with identifier bits 0..63. If all are equal, `selected` rises. On any difference the slave goes idle: `tx_bit` stays 1, nothing is forwarded, and further commands have no effect until a bus reset.
- R5: After command F0h, each bit position i (0..63) takes a read slot returning identifier bit i, then a read slot returning its complement, then a write slot carrying the master's choice. If the choice equals bit i the slave moves on to i+1. After position 63 it is selected.
- R6: During search, a slave whose bit differs from the master's choice drops out: `tx_bit` stays 1 and `selected` stays 0 until a bus reset.
- R7: A command byte other than 33h, 55h, CCh or F0h leaves the slave idle until a bus reset. In that state `tx_bit` is 1 and later bytes, including CCh, do not select it.
- R8: While selected, each write slot gives a one-cycle `fwd_valid` pulse with `fwd_bit` equal to `wr_bit` in the next cycle. A read slot raises `fn_rd` in the same cycle, and `tx_bit` follows `fn_tx_bit`.
- R9: A `bus_reset` pulse returns the block to command reception from any state and clears `selected` in the next cycle.
- R10: Command bits are taken least significant bit first, so the byte AAh is unknown even though its reversed order is 55h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | One-cycle strobe: reset pulse seen on the wire |
| wr_slot | input | 1 | One-cycle strobe: master wrote a bit |
| wr_bit | input | 1 | Bit value of the write slot |
| rd_slot | input | 1 | One-cycle strobe: master read a bit (consumes `tx_bit`) |
| serial_num | input | SERIAL_W | Serial number field of the identifier |
| fn_tx_bit | input | 1 | Bit offered by the function layer for read slots while selected |
| tx_bit | output | 1 | Bit presented for the next read slot, 1 = released |
| selected | output | 1 | Slave is addressed and owns later slots |
| fwd_valid | output | 1 | Forwarded write slot strobe to the function layer |
| fwd_bit | output | 1 | Forwarded write slot value |
| fn_rd | output | 1 | Read slot belongs to the function layer |

## Verification
The bench drives two slaves with different serial numbers, plus a third that uses a known published identifier, all from the same slot strobes. It reads each identifier in full and compares it with a check byte computed in the bench. The known identifier separates a correct polynomial and bit order from a plausible but wrong one. Matching is tried with the exact identifier and with a difference in the first and in the last bit, which tells a full-length compare apart from an early exit or a shortened one. Two search passes, one preferring 0 and one preferring 1 on conflicts, model the wired-AND of both slaves at every bit. Each pass must end with exactly the opposite slave selected. Skip, unknown and bit-reversed opcodes, and bus resets in the middle of a sequence, show that only the defined opcodes select and that a reset always brings back command reception.

// File: rtl/ow_na_pkg.sv
package ow_na_pkg;

   localparam int CHK_W = 8;
   localparam int CMD_W = 8;

   localparam logic [CMD_W-1:0] OP_READ_ID   = 8'h33;
   localparam logic [CMD_W-1:0] OP_MATCH_ID  = 8'h55;
   localparam logic [CMD_W-1:0] OP_SKIP_ID   = 8'hCC;
   localparam logic [CMD_W-1:0] OP_SEARCH_ID = 8'hF0;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_READ,
      ST_MATCH,
      ST_SEARCH,
      ST_SEL,
      ST_IDLE
   } na_state_t;

   // search sub-steps for one bit position
   localparam logic [1:0] PH_TRUE   = 2'd0;
   localparam logic [1:0] PH_COMP   = 2'd1;
   localparam logic [1:0] PH_CHOICE = 2'd2;

   // one LSB-first step of the x^8+x^5+x^4+1 check register
   function automatic logic [CHK_W-1:0] chk_step(input logic [CHK_W-1:0] c, input logic b);
      logic fb;
      logic [CHK_W-1:0] r;
      fb = c[0] ^ b;
      r  = c >> 1;
      if (fb) r = r ^ 8'h8C;
      return r;
   endfunction

endpackage

// File: rtl/na_chk_gen.sv
module na_chk_gen
   import ow_na_pkg::*;
#(
   parameter int DATA_W = 56
) (
   input  logic [DATA_W-1:0] data,
   output logic [CHK_W-1:0]  chk
);
   logic [CHK_W-1:0] stage [DATA_W+1];

   assign stage[0] = '0;

   for (genvar g = 0; g < DATA_W; g++) begin : g_step
      assign stage[g+1] = chk_step(stage[g], data[g]);
   end

   assign chk = stage[DATA_W];
endmodule

// File: rtl/na_cmd_rx.sv
module na_cmd_rx
   import ow_na_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             en,
   input  logic             bit_valid,
   input  logic             bit_in,
   output logic             last,
   output logic [CMD_W-1:0] next_byte
);
   localparam int CNT_W = $clog2(CMD_W + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_W - 1);

   logic [CMD_W-2:0] sr;
   logic [CNT_W-1:0] cnt;
   logic             take;

   assign take      = en && bit_valid && (cnt <= CNT_LAST);
   assign next_byte = {bit_in, sr};
   assign last      = take && (cnt == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr  <= '0;
         cnt <= '0;
      end else if (clear) begin
         sr  <= '0;
         cnt <= '0;
      end else if (take) begin
         sr  <= next_byte[CMD_W-1:1];
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/ow_netaddr_layer.sv
module ow_netaddr_layer
   import ow_na_pkg::*;
#(
   parameter int                  FAMILY_W = 8,
   parameter int                  SERIAL_W = 48,
   parameter logic [FAMILY_W-1:0] FAMILY   = 8'h09
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_reset,
   input  logic                wr_slot,
   input  logic                wr_bit,
   input  logic                rd_slot,
   input  logic [SERIAL_W-1:0] serial_num,
   input  logic                fn_tx_bit,
   output logic                tx_bit,
   output logic                selected,
   output logic                fwd_valid,
   output logic                fwd_bit,
   output logic                fn_rd
);
   localparam int PREFIX_W = FAMILY_W + SERIAL_W;
   localparam int ID_W     = PREFIX_W + CHK_W;
   localparam int IDX_W    = $clog2(ID_W);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_W - 1);

   if (FAMILY_W < 1 || SERIAL_W < 1) begin : g_bad_widths
      $error("ow_netaddr_layer: identifier fields must be at least one bit wide");
   end
   if (ID_W != (1 << IDX_W)) begin : g_bad_id_w
      $error("ow_netaddr_layer: identifier width must be a power of two");
   end

   logic [PREFIX_W-1:0] prefix;
   logic [CHK_W-1:0]    chk;
   logic [ID_W-1:0]     id_word;

   assign prefix  = {serial_num, FAMILY};
   assign id_word = {chk, prefix};

   na_chk_gen #(.DATA_W(PREFIX_W)) u_chk (
      .data (prefix),
      .chk  (chk)
   );

   na_state_t        state;
   logic [IDX_W-1:0] idx;
   logic [1:0]       phase;
   logic             cmd_last;
   logic [CMD_W-1:0] cmd_byte;
   logic             cur_bit;
   logic             at_last;

   na_cmd_rx u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (bus_reset),
      .en        (state == ST_CMD),
      .bit_valid (wr_slot),
      .bit_in    (wr_bit),
      .last      (cmd_last),
      .next_byte (cmd_byte)
   );

   assign cur_bit  = id_word[idx];
   assign at_last  = (idx == IDX_LAST);
   assign selected = (state == ST_SEL);
   assign fn_rd    = rd_slot && (state == ST_SEL);

   always_comb begin
      case (state)
         ST_READ:   tx_bit = cur_bit;
         ST_SEARCH: tx_bit = (phase == PH_TRUE) ? cur_bit :
                             (phase == PH_COMP) ? ~cur_bit : 1'b1;
         ST_SEL:    tx_bit = fn_tx_bit;
         default:   tx_bit = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_CMD;
         idx       <= '0;
         phase     <= PH_TRUE;
         fwd_valid <= 1'b0;
         fwd_bit   <= 1'b0;
      end else begin
         fwd_valid <= 1'b0;
         if (bus_reset) begin
            state <= ST_CMD;
            idx   <= '0;
            phase <= PH_TRUE;
         end else begin
            case (state)
               ST_CMD: begin
                  if (cmd_last) begin
                     idx   <= '0;
                     phase <= PH_TRUE;
                     case (cmd_byte)
                        OP_READ_ID:   state <= ST_READ;
                        OP_MATCH_ID:  state <= ST_MATCH;
                        OP_SKIP_ID:   state <= ST_SEL;
                        OP_SEARCH_ID: state <= ST_SEARCH;
                        default:      state <= ST_IDLE;
                     endcase
                  end
               end
               ST_READ: begin
                  if (rd_slot) begin
                     if (at_last) state <= ST_SEL;
                     else         idx   <= idx + 1'b1;
                  end
               end
               ST_MATCH: begin
                  if (wr_slot) begin
                     if (wr_bit != cur_bit) state <= ST_IDLE;
                     else if (at_last)      state <= ST_SEL;
                     else                   idx   <= idx + 1'b1;
                  end
               end
               ST_SEARCH: begin
                  case (phase)
                     PH_TRUE: if (rd_slot) phase <= PH_COMP;
                     PH_COMP: if (rd_slot) phase <= PH_CHOICE;
                     default: begin
                        if (wr_slot) begin
                           if (wr_bit != cur_bit) state <= ST_IDLE;
                           else if (at_last)      state <= ST_SEL;
                           else begin
                              idx   <= idx + 1'b1;
                              phase <= PH_TRUE;
                           end
                        end
                     end
                  endcase
               end
               ST_SEL: begin
                  if (wr_slot) begin
                     fwd_valid <= 1'b1;
                     fwd_bit   <= wr_bit;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R9
   reset_clears_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> !selected);

   // R8
   fwd_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> selected);

   // R3
   sel_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (selected && !bus_reset) |=> selected);

   // R4
   idle_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !bus_reset) |=> (state == ST_IDLE && tx_bit && !selected));

   // R5
   search_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SEARCH && phase == PH_CHOICE && !wr_slot && !bus_reset)
      |=> (state == ST_SEARCH && phase == PH_CHOICE && $stable(idx)));

endmodule

// File: tb/ow_netaddr_layer_test.sv
module ow_netaddr_layer_test;
   localparam time TCLK = 20ns;
   localparam logic [47:0] SER_A = 48'h00A1B2C3D4E5;
   localparam logic [47:0] SER_B = 48'h00A1B2C3D4E1;
   localparam logic [47:0] SER_K = 48'h000001B81C;
   localparam logic [63:0] KNOWN_K = 64'hA200000001B81C02;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_reset = 1'b0, wr_slot = 1'b0, wr_bit = 1'b0, rd_slot = 1'b0;
   logic fn_tx_bit = 1'b1;
   logic tx_a, tx_b, tx_k, sel_a, sel_b, sel_k;
   logic fv_a, fv_b, fv_k, fb_a, fb_b, fb_k, frd_a, frd_b, frd_k;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(TCLK/2) clk = ~clk;

   ow_netaddr_layer uut (
      .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .wr_slot(wr_slot), .wr_bit(wr_bit),
      .rd_slot(rd_slot), .serial_num(SER_A), .fn_tx_bit(fn_tx_bit), .tx_bit(tx_a),
      .selected(sel_a), .fwd_valid(fv_a), .fwd_bit(fb_a), .fn_rd(frd_a));

   ow_netaddr_layer uut_b (
      .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .wr_slot(wr_slot), .wr_bit(wr_bit),
      .rd_slot(rd_slot), .serial_num(SER_B), .fn_tx_bit(fn_tx_bit), .tx_bit(tx_b),
      .selected(sel_b), .fwd_valid(fv_b), .fwd_bit(fb_b), .fn_rd(frd_b));

   ow_netaddr_layer #(.FAMILY(8'h02)) uut_k (
      .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .wr_slot(wr_slot), .wr_bit(wr_bit),
      .rd_slot(rd_slot), .serial_num(SER_K), .fn_tx_bit(fn_tx_bit), .tx_bit(tx_k),
      .selected(sel_k), .fwd_valid(fv_k), .fwd_bit(fb_k), .fn_rd(frd_k));

   // shift-register model: input xor stage 0 feeds bit 7 and taps at 3 and 2
   function automatic logic [63:0] make_id(input logic [7:0] fam, input logic [47:0] ser);
      logic [55:0] pre;
      logic [7:0]  r;
      logic        fb;
      pre = {ser, fam};
      r = 8'h00;
      for (int i = 0; i < 56; i++) begin
         fb = pre[i] ^ r[0];
         r  = {fb, r[7:1]};
         r[3] = r[3] ^ fb;
         r[2] = r[2] ^ fb;
      end
      return {r, pre};
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic pulse_reset();
      bus_reset = 1'b1; tick(); bus_reset = 1'b0;
   endtask

   task automatic slot_wr(input logic b);
      wr_slot = 1'b1; wr_bit = b; tick(); wr_slot = 1'b0;
   endtask

   task automatic slot_rd(output logic ta, output logic tb, output logic tk);
      ta = tx_a; tb = tx_b; tk = tx_k;
      rd_slot = 1'b1; tick(); rd_slot = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) slot_wr(v[i]);
   endtask

   task automatic search_pass(input logic pref, input logic [63:0] ida, input logic [63:0] idb,
                              output int bad, output logic act_a, output logic act_b);
      logic ta, tb, tk, ea, eb, c;
      bad = 0; act_a = 1'b1; act_b = 1'b1;
      for (int i = 0; i < 64; i++) begin
         ea = (!act_a | ida[i]) & (!act_b | idb[i]);
         slot_rd(ta, tb, tk);
         if ((ta & tb) !== ea) bad++;
         eb = (!act_a | ~ida[i]) & (!act_b | ~idb[i]);
         slot_rd(ta, tb, tk);
         if ((ta & tb) !== eb) bad++;
         c = (ea != eb) ? ea : pref;
         act_a = act_a & (ida[i] == c);
         act_b = act_b & (idb[i] == c);
         slot_wr(c);
      end
   endtask

   initial begin
      #(TCLK * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [63:0] id_a, id_b, ra, rb, rk, tmp;
      logic ta, tb, tk, aa, ab;
      int bad;
      id_a = make_id(8'h09, SER_A);
      id_b = make_id(8'h09, SER_B);

      tick(); tick();
      // R1 reset state
      check(!sel_a && !fv_a && !frd_a && tx_a, "R1", {sel_a, fv_a, frd_a, tx_a}, 64'h1);
      rst_n = 1'b1; tick();
      check(!sel_a && !sel_b && tx_a && tx_b, "R1", {sel_a, sel_b, tx_a, tx_b}, 64'h3);

      // R2 read identifier
      pulse_reset(); send_byte(8'h33);
      for (int i = 0; i < 64; i++) begin
         slot_rd(ta, tb, tk); ra[i] = ta; rb[i] = tb; rk[i] = tk;
      end
      check(ra == id_a, "R2 id a", ra, id_a);
      check(rb == id_b, "R2 id b", rb, id_b);
      check(rk == KNOWN_K, "R2 known check byte", rk, KNOWN_K);
      check(sel_a && sel_b, "R2 selected after read", {sel_a, sel_b}, 64'h3);

      // R9 reset while selected
      pulse_reset();
      check(!sel_a && !sel_b, "R9 reset clears", {sel_a, sel_b}, 64'h0);

      // R3 skip
      for (int i = 0; i < 7; i++) slot_wr(8'hCC >> i);
      check(!sel_a, "R3 seven bits", sel_a, 0);
      slot_wr(1'b1);
      check(sel_a && sel_b, "R3 skip selects", {sel_a, sel_b}, 64'h3);

      // R8 forwarding
      slot_wr(1'b1);
      check(fv_a && fb_a, "R8 fwd one", {fv_a, fb_a}, 64'h3);
      tick();
      check(!fv_a, "R8 fwd pulse ends", fv_a, 0);
      slot_wr(1'b0);
      check(fv_a && !fb_a, "R8 fwd zero", {fv_a, fb_a}, 64'h2);
      fn_tx_bit = 1'b0; rd_slot = 1'b1; #1;
      check(frd_a && !tx_a, "R8 read to function", {frd_a, tx_a}, 64'h2);
      tick(); rd_slot = 1'b0; fn_tx_bit = 1'b1;

      // R4 exact match
      pulse_reset(); send_byte(8'h55);
      for (int i = 0; i < 64; i++) slot_wr(id_a[i]);
      check(sel_a && !sel_b, "R4 match a only", {sel_a, sel_b}, 64'h2);

      // R4 mismatch in last bit
      pulse_reset(); send_byte(8'h55);
      tmp = id_a; tmp[63] = ~tmp[63];
      for (int i = 0; i < 64; i++) slot_wr(tmp[i]);
      check(!sel_a, "R4 last bit mismatch", sel_a, 0);
      slot_rd(ta, tb, tk);
      check(ta, "R4 released", ta, 1);
      slot_wr(1'b1);
      check(!fv_a, "R4 no forward", fv_a, 0);
      send_byte(8'hCC);
      check(!sel_a, "R4 later skip ignored", sel_a, 0);

      // R4 mismatch in first bit
      pulse_reset(); send_byte(8'h55);
      tmp = id_b; tmp[0] = ~tmp[0];
      for (int i = 0; i < 64; i++) slot_wr(tmp[i]);
      check(!sel_b && !sel_a, "R4 first bit mismatch", {sel_a, sel_b}, 64'h0);

      // R5 R6 search preferring 0
      pulse_reset(); send_byte(8'hF0);
      search_pass(1'b0, id_a, id_b, bad, aa, ab);
      check(bad == 0, "R5 search bits pass0", bad, 0);
      check(aa != ab && sel_a == aa && sel_b == ab, "R6 search winner pass0", {sel_a, sel_b}, {aa, ab});

      // R5 R6 search preferring 1
      pulse_reset(); send_byte(8'hF0);
      search_pass(1'b1, id_a, id_b, bad, aa, ab);
      check(bad == 0, "R5 search bits pass1", bad, 0);
      check(aa != ab && sel_a == aa && sel_b == ab, "R6 search winner pass1", {sel_a, sel_b}, {aa, ab});
      slot_rd(ta, tb, tk);
      check(aa ? tb : ta, "R6 loser released", aa ? tb : ta, 1);

      // R7 unknown opcode
      pulse_reset(); send_byte(8'hA5);
      send_byte(8'hCC);
      slot_rd(ta, tb, tk);
      check(!sel_a && ta, "R7 unknown idle", {sel_a, ta}, 64'h1);

      // R10 bit order: AAh is not a command
      pulse_reset(); send_byte(8'hAA);
      for (int i = 0; i < 64; i++) slot_wr(id_a[i]);
      check(!sel_a, "R10 reversed match opcode", sel_a, 0);

      // R9 reset in mid match
      pulse_reset(); send_byte(8'h55);
      for (int i = 0; i < 10; i++) slot_wr(id_a[i]);
      pulse_reset(); send_byte(8'hCC);
      check(sel_a && sel_b, "R9 mid sequence reset", {sel_a, sel_b}, 64'h3);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule